// File: doc/BRIEF.md
# Backlight PWM Start-Up Sequencer

This block runs once after power-up, on a start strobe, and makes sure the backlight PWM register set holds settings that can be used. It drives a simple register master port to read the control register and looks at the active-count field. A count of 0 or 1 means the register set has been wiped. In that case the block writes back a shadow copy kept from an earlier good run, or fixed fallback values when no copy exists. A count of 2 or more means the set is healthy, and the block copies it into the shadow store.

After either branch the block always does three read-modify-write steps, in this order. It sets the driver-ownership bit in a scratch register, it sets the PWM output enable in the control register, and it clears the group lock bit. It then pulses a done flag. The PWM generator itself lives elsewhere.

The shadow store is held in flip-flops inside the block. Reset clears it, and the store survives any number of later start strobes.

Top module: `bl_pwm_init`

## Requirements
- R1: After reset `done` and `reg_req` are low and the shadow store is empty, so the next invalid count takes the fallback path.
- R2: A `start` pulse while idle begins with a read of the control register. The register addresses are control 0, control-2 1, period 2, divider 3, scratch 4 and lock 5. The active count is control bits [15:0], and a value of 0 or 1 is invalid.
- R3: With a valid count, the block reads control-2, period and divider in that order. It stores the control word, control-2, period and divider bits [31:16] as the shadow copy, and writes none of them.
- R4: With an invalid count and a shadow copy whose saved control word is non-zero, the block writes the saved control, control-2 and period words in that order. It then reads the divider and writes it back with bits [31:16] replaced by the saved field and bits [15:0] kept.
- R5: With an invalid count and no shadow copy, the block writes control = 0xC000FA00, then period = 0x000C0FA0, and leaves control-2 and the divider untouched.
- R6: The block reads the scratch register and writes it back with bit 29 set and every other bit kept.
- R7: The block then reads control and writes it back with bit 31 (output enable) set and every other bit kept.
- R8: The last access is a read-modify-write of the lock register that clears bit 0 and keeps the other bits. `done` is high for exactly one cycle, the cycle after that write is acknowledged.
- R9: A request holds `reg_req`, `reg_addr`, `reg_we` and `reg_wdata` steady until `reg_ack` is seen with it. Read data is taken in the acknowledge cycle.
- R10: A `start` pulse while a sequence is running has no effect on the access sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one initialisation sequence |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | 8 | Register word address |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid with `reg_ack` |
| reg_ack | input | 1 | Access complete this cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each access completes in the cycle where `reg_ack` is high. The next request follows on the next clock edge, so the bench's register model acknowledges, then commits writes and logs accesses on the falling edge after the completing rising edge, and the bench compares the complete ordered access log only after the sequence ends. `done` is due one rising edge after the lock write is acknowledged. The bench samples it shortly after rising edges, expects it high once and low on the following cycle. Wait states of zero to two cycles per access are injected, and the model checks at every stalled falling edge that the request did not change.

// File: rtl/bl_init_pkg.sv
package bl_init_pkg;
   typedef enum logic [4:0] {
      ST_IDLE,
      ST_RD_CTRL,
      ST_WR_CTRL_SH,
      ST_WR_C2_SH,
      ST_WR_PER_SH,
      ST_RD_REF_R,
      ST_WR_REF_R,
      ST_WR_CTRL_DEF,
      ST_WR_PER_DEF,
      ST_RD_C2,
      ST_RD_PER,
      ST_RD_REF_S,
      ST_RD_SCR,
      ST_WR_SCR,
      ST_RD_CTRL_EN,
      ST_WR_CTRL_EN,
      ST_RD_LOCK,
      ST_WR_LOCK
   } step_t;
endpackage

// File: rtl/bl_init_shadow.sv
module bl_init_shadow #(
   parameter int DATA_W  = 32,
   parameter int REF_LSB = 16,
   parameter int REF_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_c2,
   input  logic              cap_per,
   input  logic              cap_ref,
   input  logic [DATA_W-1:0] ctrl_in,
   input  logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] sh_ctrl,
   output logic [DATA_W-1:0] sh_c2,
   output logic [DATA_W-1:0] sh_per,
   output logic [REF_W-1:0]  sh_ref,
   output logic              has_copy
);
   logic sh_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_ctrl  <= '0;
         sh_c2    <= '0;
         sh_per   <= '0;
         sh_ref   <= '0;
         sh_valid <= 1'b0;
      end else begin
         if (cap_c2) begin
            sh_ctrl <= ctrl_in;
            sh_c2   <= rdata;
         end
         if (cap_per) sh_per <= rdata;
         if (cap_ref) begin
            sh_ref   <= rdata[REF_LSB +: REF_W];
            sh_valid <= 1'b1;
         end
      end
   end

   // a zero saved control word is treated as no copy at all
   assign has_copy = sh_valid && (sh_ctrl != '0);
endmodule

// File: rtl/bl_init_datapath.sv
module bl_init_datapath
   import bl_init_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 32,
   parameter int                REF_LSB   = 16,
   parameter int                REF_W     = 16,
   parameter int                EN_BIT    = 31,
   parameter int                CLAIM_BIT = 29,
   parameter int                LOCK_BIT  = 0,
   parameter logic [ADDR_W-1:0] A_CTRL    = 0,
   parameter logic [ADDR_W-1:0] A_C2      = 1,
   parameter logic [ADDR_W-1:0] A_PER     = 2,
   parameter logic [ADDR_W-1:0] A_REF     = 3,
   parameter logic [ADDR_W-1:0] A_SCR     = 4,
   parameter logic [ADDR_W-1:0] A_LOCK    = 5,
   parameter logic [DATA_W-1:0] DEF_CTRL  = 32'hC000_FA00,
   parameter logic [DATA_W-1:0] DEF_PER   = 32'h000C_0FA0
) (
   input  step_t             step,
   input  logic [DATA_W-1:0] rd_q,
   input  logic [DATA_W-1:0] sh_ctrl,
   input  logic [DATA_W-1:0] sh_c2,
   input  logic [DATA_W-1:0] sh_per,
   input  logic [REF_W-1:0]  sh_ref,
   output logic              acc_we,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [DATA_W-1:0] acc_wdata
);
   logic [DATA_W-1:0] ref_merged;

   always_comb begin
      ref_merged = rd_q;
      ref_merged[REF_LSB +: REF_W] = sh_ref;
   end

   always_comb begin
      acc_we    = 1'b0;
      acc_addr  = A_CTRL;
      acc_wdata = '0;
      unique case (step)
         ST_WR_CTRL_SH:  begin acc_we = 1'b1; acc_addr = A_CTRL; acc_wdata = sh_ctrl; end
         ST_WR_C2_SH:    begin acc_we = 1'b1; acc_addr = A_C2;   acc_wdata = sh_c2;   end
         ST_WR_PER_SH:   begin acc_we = 1'b1; acc_addr = A_PER;  acc_wdata = sh_per;  end
         ST_RD_REF_R:    acc_addr = A_REF;
         ST_WR_REF_R:    begin acc_we = 1'b1; acc_addr = A_REF;  acc_wdata = ref_merged; end
         ST_WR_CTRL_DEF: begin acc_we = 1'b1; acc_addr = A_CTRL; acc_wdata = DEF_CTRL; end
         ST_WR_PER_DEF:  begin acc_we = 1'b1; acc_addr = A_PER;  acc_wdata = DEF_PER;  end
         ST_RD_C2:       acc_addr = A_C2;
         ST_RD_PER:      acc_addr = A_PER;
         ST_RD_REF_S:    acc_addr = A_REF;
         ST_RD_SCR:      acc_addr = A_SCR;
         ST_WR_SCR: begin
            acc_we = 1'b1; acc_addr = A_SCR;
            acc_wdata = rd_q | (DATA_W'(1) << CLAIM_BIT);
         end
         ST_WR_CTRL_EN: begin
            acc_we = 1'b1; acc_addr = A_CTRL;
            acc_wdata = rd_q | (DATA_W'(1) << EN_BIT);
         end
         ST_RD_LOCK:     acc_addr = A_LOCK;
         ST_WR_LOCK: begin
            acc_we = 1'b1; acc_addr = A_LOCK;
            acc_wdata = rd_q & ~(DATA_W'(1) << LOCK_BIT);
         end
         default:        acc_addr = A_CTRL;
      endcase
   end
endmodule

// File: rtl/bl_init_fsm.sv
module bl_init_fsm
   import bl_init_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int CNT_LSB = 0,
   parameter int CNT_W   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ack,
   input  logic              acc_we,
   input  logic [DATA_W-1:0] rdata,
   input  logic              has_copy,
   output step_t             step,
   output logic              req,
   output logic [DATA_W-1:0] rd_q,
   output logic              cap_c2,
   output logic              cap_per,
   output logic              cap_ref,
   output logic              done
);
   localparam logic [CNT_W-1:0] CNT_FIRST_OK = CNT_W'(2);

   step_t step_nx;
   logic  cnt_ok;

   assign req    = (step != ST_IDLE);
   assign cnt_ok = rdata[CNT_LSB +: CNT_W] >= CNT_FIRST_OK;

   assign cap_c2  = ack && (step == ST_RD_C2);
   assign cap_per = ack && (step == ST_RD_PER);
   assign cap_ref = ack && (step == ST_RD_REF_S);

   always_comb begin
      step_nx = step;
      unique case (step)
         ST_IDLE:        if (start) step_nx = ST_RD_CTRL;
         ST_RD_CTRL:     if (ack) step_nx = cnt_ok   ? ST_RD_C2 :
                                           has_copy ? ST_WR_CTRL_SH : ST_WR_CTRL_DEF;
         ST_WR_CTRL_SH:  if (ack) step_nx = ST_WR_C2_SH;
         ST_WR_C2_SH:    if (ack) step_nx = ST_WR_PER_SH;
         ST_WR_PER_SH:   if (ack) step_nx = ST_RD_REF_R;
         ST_RD_REF_R:    if (ack) step_nx = ST_WR_REF_R;
         ST_WR_REF_R:    if (ack) step_nx = ST_RD_SCR;
         ST_WR_CTRL_DEF: if (ack) step_nx = ST_WR_PER_DEF;
         ST_WR_PER_DEF:  if (ack) step_nx = ST_RD_SCR;
         ST_RD_C2:       if (ack) step_nx = ST_RD_PER;
         ST_RD_PER:      if (ack) step_nx = ST_RD_REF_S;
         ST_RD_REF_S:    if (ack) step_nx = ST_RD_SCR;
         ST_RD_SCR:      if (ack) step_nx = ST_WR_SCR;
         ST_WR_SCR:      if (ack) step_nx = ST_RD_CTRL_EN;
         ST_RD_CTRL_EN:  if (ack) step_nx = ST_WR_CTRL_EN;
         ST_WR_CTRL_EN:  if (ack) step_nx = ST_RD_LOCK;
         ST_RD_LOCK:     if (ack) step_nx = ST_WR_LOCK;
         ST_WR_LOCK:     if (ack) step_nx = ST_IDLE;
         default:        step_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step <= ST_IDLE;
         rd_q <= '0;
         done <= 1'b0;
      end else begin
         step <= step_nx;
         done <= ack && (step == ST_WR_LOCK);
         if (ack && req && !acc_we) rd_q <= rdata;
      end
   end
endmodule

// File: rtl/bl_pwm_init.sv
module bl_pwm_init
   import bl_init_pkg::*;
#(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 32,
   parameter int                CNT_LSB   = 0,
   parameter int                CNT_W     = 16,
   parameter int                REF_LSB   = 16,
   parameter int                REF_W     = 16,
   parameter int                EN_BIT    = 31,
   parameter int                CLAIM_BIT = 29,
   parameter int                LOCK_BIT  = 0,
   parameter logic [ADDR_W-1:0] A_CTRL    = 0,
   parameter logic [ADDR_W-1:0] A_C2      = 1,
   parameter logic [ADDR_W-1:0] A_PER     = 2,
   parameter logic [ADDR_W-1:0] A_REF     = 3,
   parameter logic [ADDR_W-1:0] A_SCR     = 4,
   parameter logic [ADDR_W-1:0] A_LOCK    = 5,
   parameter logic [DATA_W-1:0] DEF_CTRL  = 32'hC000_FA00,
   parameter logic [DATA_W-1:0] DEF_PER   = 32'h000C_0FA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              reg_req,
   output logic              reg_we,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_wdata,
   input  logic [DATA_W-1:0] reg_rdata,
   input  logic              reg_ack,
   output logic              done
);
   generate
      if (CNT_W < 2 || CNT_LSB + CNT_W > DATA_W) begin : g_bad_cnt
         $error("active-count field does not fit the data word");
      end
      if (REF_W < 1 || REF_LSB + REF_W > DATA_W) begin : g_bad_ref
         $error("divider field does not fit the data word");
      end
      if (EN_BIT >= DATA_W || CLAIM_BIT >= DATA_W || LOCK_BIT >= DATA_W) begin : g_bad_bit
         $error("control bit position outside the data word");
      end
   endgenerate

   step_t             step;
   logic [DATA_W-1:0] rd_q, sh_ctrl, sh_c2, sh_per;
   logic [REF_W-1:0]  sh_ref;
   logic              has_copy, cap_c2, cap_per, cap_ref, ack_q;

   assign ack_q = reg_ack && reg_req;

   bl_init_fsm #(.DATA_W(DATA_W), .CNT_LSB(CNT_LSB), .CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .ack(ack_q), .acc_we(reg_we),
      .rdata(reg_rdata), .has_copy(has_copy), .step(step), .req(reg_req),
      .rd_q(rd_q), .cap_c2(cap_c2), .cap_per(cap_per), .cap_ref(cap_ref),
      .done(done)
   );

   bl_init_shadow #(.DATA_W(DATA_W), .REF_LSB(REF_LSB), .REF_W(REF_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .cap_c2(cap_c2), .cap_per(cap_per),
      .cap_ref(cap_ref), .ctrl_in(rd_q), .rdata(reg_rdata), .sh_ctrl(sh_ctrl),
      .sh_c2(sh_c2), .sh_per(sh_per), .sh_ref(sh_ref), .has_copy(has_copy)
   );

   bl_init_datapath #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REF_LSB(REF_LSB), .REF_W(REF_W),
      .EN_BIT(EN_BIT), .CLAIM_BIT(CLAIM_BIT), .LOCK_BIT(LOCK_BIT),
      .A_CTRL(A_CTRL), .A_C2(A_C2), .A_PER(A_PER), .A_REF(A_REF),
      .A_SCR(A_SCR), .A_LOCK(A_LOCK), .DEF_CTRL(DEF_CTRL), .DEF_PER(DEF_PER)
   ) u_dp (
      .step(step), .rd_q(rd_q), .sh_ctrl(sh_ctrl), .sh_c2(sh_c2),
      .sh_per(sh_per), .sh_ref(sh_ref), .acc_we(reg_we), .acc_addr(reg_addr),
      .acc_wdata(reg_wdata)
   );
endmodule

// File: rtl/bl_pwm_init_chk.sv
module bl_pwm_init_chk #(
   parameter int                ADDR_W    = 8,
   parameter int                DATA_W    = 32,
   parameter int                CLAIM_BIT = 29,
   parameter int                LOCK_BIT  = 0,
   parameter logic [ADDR_W-1:0] A_SCR     = 4,
   parameter logic [ADDR_W-1:0] A_LOCK    = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_req,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              reg_ack,
   input logic              done
);
   // R9
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata));

   // R6
   claim_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && reg_we && reg_addr == A_SCR |-> reg_wdata[CLAIM_BIT]);

   // R8
   unlock_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && reg_we && reg_addr == A_LOCK |-> !reg_wdata[LOCK_BIT]);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_follows_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(reg_req && reg_ack && reg_we && reg_addr == A_LOCK));

   // R1
   idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !reg_req);
endmodule

bind bl_pwm_init bl_pwm_init_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLAIM_BIT(CLAIM_BIT),
   .LOCK_BIT(LOCK_BIT), .A_SCR(A_SCR), .A_LOCK(A_LOCK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack), .done(done)
);

// File: tb/bl_pwm_init_test.sv
`timescale 1ns/1ps
module bl_pwm_init_test;
   localparam int CTRL = 0, C2 = 1, PER = 2, REFD = 3, SCR = 4, LOCK = 5;

   logic        clk = 0, rst_n = 0, start = 0;
   logic        reg_req, reg_we, reg_ack = 0, done;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata, reg_rdata = 0;

   bl_pwm_init uut (
      .clk(clk), .rst_n(rst_n), .start(start), .reg_req(reg_req), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_ack(reg_ack), .done(done)
   );

   always #2 clk = ~clk;

   int nchk = 0, nerr = 0, hold_viol = 0, wait_cfg = 0, wcnt = 0;
   bit reported = 0;
   logic [31:0] regs [0:7];
   logic        log_we [0:31];
   logic [7:0]  log_addr [0:31];
   logic [31:0] log_data [0:31];
   int          log_n = 0;
   logic        exp_we [0:31];
   logic [7:0]  exp_addr [0:31];
   logic [31:0] exp_data [0:31];
   int          exp_n = 0;
   logic        lat_we, pend = 0, p_we;
   logic [7:0]  lat_addr, p_addr;
   logic [31:0] lat_wd, p_wd;

   // register model: acknowledge after wait_cfg stall cycles, commit at next falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         reg_ack = 0; wcnt = 0; pend = 0;
      end else begin
         if (reg_ack) begin
            if (lat_we) regs[lat_addr[2:0]] = lat_wd;
            if (log_n < 32) begin
               log_we[log_n] = lat_we; log_addr[log_n] = lat_addr; log_data[log_n] = lat_wd;
            end
            log_n++;
            reg_ack = 0;
         end else if (pend) begin
            if (!(reg_req && reg_addr == p_addr && reg_we == p_we && reg_wdata == p_wd))
               hold_viol++;
         end
         pend = 0;
         if (reg_req) begin
            if (wcnt >= wait_cfg) begin
               reg_ack = 1; reg_rdata = regs[reg_addr[2:0]];
               lat_we = reg_we; lat_addr = reg_addr; lat_wd = reg_wdata; wcnt = 0;
            end else begin
               wcnt++; pend = 1; p_we = reg_we; p_addr = reg_addr; p_wd = reg_wdata;
            end
         end
      end
   end

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic ex(input logic we, input int a, input logic [31:0] d);
      exp_we[exp_n] = we; exp_addr[exp_n] = 8'(a); exp_data[exp_n] = d; exp_n++;
   endtask

   task automatic run_seq(input int dly, input bit poke);
      int cyc = 0;
      wait_cfg = dly; log_n = 0; hold_viol = 0;
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      forever begin
         @(posedge clk); #1;
         cyc++;
         if (poke && cyc == 4) begin @(negedge clk); start = 1; @(negedge clk); start = 0; end
         if (done) break;
      end
      @(posedge clk); #1;
      chk("R8 done one cycle", 32'(done), 32'd0);
   endtask

   task automatic cmp_log(input string tag);
      chk({tag, " access count"}, 32'(log_n), 32'(exp_n));
      for (int i = 0; i < exp_n && i < log_n; i++) begin
         chk({tag, " access kind/addr"}, {23'd0, log_we[i], log_addr[i]}, {23'd0, exp_we[i], exp_addr[i]});
         if (exp_we[i]) chk({tag, " write data"}, log_data[i], exp_data[i]);
      end
      chk("R9 request held while stalled", 32'(hold_viol), 32'd0);
      chk("R8 final access unlocks", {23'd0, log_we[log_n-1], log_addr[log_n-1]}, {23'd0, 1'b1, 8'(LOCK)});
   endtask

   task automatic t_reset();
      chk("R1 done after reset", 32'(done), 0);
      chk("R1 req after reset", 32'(reg_req), 0);
   endtask

   task automatic t_fallback(input string tag);
      regs[CTRL] = 32'h0000_0001; regs[C2] = 32'h5555_0000; regs[PER] = 32'h0;
      regs[REFD] = 32'h0000_7777; regs[SCR] = 32'h0000_1234; regs[LOCK] = 32'hFFFF_FFFF;
      exp_n = 0;
      ex(0, CTRL, 0); ex(1, CTRL, 32'hC000_FA00); ex(1, PER, 32'h000C_0FA0);
      ex(0, SCR, 0); ex(1, SCR, 32'h2000_1234); ex(0, CTRL, 0); ex(1, CTRL, 32'hC000_FA00);
      ex(0, LOCK, 0); ex(1, LOCK, 32'hFFFF_FFFE);
      run_seq(0, 0);
      cmp_log({tag, " R5 R2 fallback"});
      chk("R5 control-2 untouched", regs[C2], 32'h5555_0000);
      chk("R5 divider untouched", regs[REFD], 32'h0000_7777);
      chk("R6 scratch claim", regs[SCR], 32'h2000_1234);
   endtask

   task automatic t_save();
      regs[CTRL] = 32'h0000_0002; regs[C2] = 32'h1111_2222; regs[PER] = 32'h0008_0100;
      regs[REFD] = 32'hABCD_5678; regs[SCR] = 32'h4000_0000; regs[LOCK] = 32'h0000_0001;
      exp_n = 0;
      ex(0, CTRL, 0); ex(0, C2, 0); ex(0, PER, 0); ex(0, REFD, 0);
      ex(0, SCR, 0); ex(1, SCR, 32'h6000_0000); ex(0, CTRL, 0); ex(1, CTRL, 32'h8000_0002);
      ex(0, LOCK, 0); ex(1, LOCK, 32'h0000_0000);
      run_seq(2, 0);
      cmp_log("R3 snapshot");
      chk("R7 enable set", regs[CTRL], 32'h8000_0002);
      chk("R3 period untouched", regs[PER], 32'h0008_0100);
   endtask

   task automatic t_restore();
      regs[CTRL] = 32'h0; regs[C2] = 32'h0; regs[PER] = 32'h0;
      regs[REFD] = 32'h0000_9999; regs[SCR] = 32'h2000_0000; regs[LOCK] = 32'h0;
      exp_n = 0;
      ex(0, CTRL, 0); ex(1, CTRL, 32'h0000_0002); ex(1, C2, 32'h1111_2222);
      ex(1, PER, 32'h0008_0100); ex(0, REFD, 0); ex(1, REFD, 32'hABCD_9999);
      ex(0, SCR, 0); ex(1, SCR, 32'h2000_0000); ex(0, CTRL, 0); ex(1, CTRL, 32'h8000_0002);
      ex(0, LOCK, 0); ex(1, LOCK, 32'h0);
      run_seq(1, 1);
      cmp_log("R4 R10 restore");
      chk("R4 divider merged", regs[REFD], 32'hABCD_9999);
      chk("R7 enable after restore", regs[CTRL], 32'h8000_0002);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) regs[i] = 0;
      repeat (3) @(posedge clk);
      #1 t_reset();
      @(negedge clk); rst_n = 1;
      t_fallback("first");
      t_save();
      t_restore();
      @(negedge clk); rst_n = 0;
      @(negedge clk); #1 t_reset();
      @(negedge clk); rst_n = 1;
      t_fallback("R1 after reset");
      report();
   end
endmodule